// File: doc/BRIEF.md
# MDIO Management Master with PHY Address Scan

This block is the station-management master of an Ethernet MAC subsystem. It drives the management clock and the bidirectional management data line (an output, an output enable and an input) to read and write 16-bit registers inside an attached PHY. A host starts a single register read or write by pulsing a start strobe with the PHY address, register number, direction and write data. When the frame is complete it gets a one-cycle done pulse, the read data and an acknowledge flag.

A second command runs a discovery sequence. It probes PHY addresses one at a time. At each address it reads the basic status register twice and keeps the second value. It stops at the first address whose status looks like a live device, then reads the two identifier registers and reports the address and the 32-bit identifier. The management clock is the system clock divided by a parameter. With the default divider and a 200 MHz system clock it runs at 2.5 MHz.

Top module: `mdio_master`

## Requirements
- R1: Every access begins with 32 ones. Each driven bit, MSB first, is placed on the data line while the management clock is low, and the clock then rises. Every clock high phase lasts exactly HALF_DIV system cycles, and every low phase is a multiple of HALF_DIV cycles.
- R2: A write drives 32 frame bits after the preamble: 01, then 01, then the 5-bit PHY address, the 5-bit register number, the pair 10 and the 16 data bits. It then gives one final low phase and one released clock cycle, so there are 65 clock rises in all. op_done pulses 131*HALF_DIV+1 cycles after the start is accepted, with op_ack at 1.
- R3: A read drives only 14 frame bits after the preamble: 01, 10, the PHY address and the register number. It then gives one final low phase and releases the line (output enable low, changed only while the clock is low). One turnaround cycle, 16 data cycles and one closing released cycle follow, 64 clock rises in all.
- R4: On a read, the input sampled at the end of the turnaround high phase is the acknowledge, and a 0 there means acknowledged. The 16 data bits are sampled MSB first at the end of each following high phase. op_done pulses for one cycle 129*HALF_DIV+1 cycles after acceptance.
- R5: When the acknowledge bit is 1, op_rdata is 0xFFFF and op_ack is 0.
- R6: While busy is high, op_start and scan_start are ignored: no frame is started, no done pulse follows and no register is changed. scan_start wins over op_start when both arrive on an idle cycle.
- R7: The scan probes addresses in the order 1, 2, up to 31, then 0, and stops at the first address judged present.
- R8: At each address the scan reads register 1 twice. The address is present only if the second value is neither 0x0000 nor 0xFFFF. The first value is discarded.
- R9: On success scan_found is 1, scan_addr is the address, and scan_id holds register 2 in bits 31:16 and register 3 in bits 15:0.
- R10: After reset, and whenever busy is low, the clock and output enable are low. No done pulse is raised after reset.
- R11: If no address is present, scan_done pulses with scan_found 0, scan_addr 0 and scan_id 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Start one register access (taken only when idle) |
| op_write | input | 1 | 1 = write, 0 = read |
| op_phy | input | 5 | PHY address of the access |
| op_reg | input | 5 | Register number of the access |
| op_wdata | input | 16 | Data for a write |
| scan_start | input | 1 | Start the address scan (taken only when idle) |
| busy | output | 1 | An access or scan is in progress |
| op_done | output | 1 | One-cycle pulse at the end of a host access |
| op_ack | output | 1 | Acknowledge of the last host access |
| op_rdata | output | 16 | Read data of the last host access |
| scan_done | output | 1 | One-cycle pulse at the end of a scan |
| scan_found | output | 1 | A present PHY was found |
| scan_addr | output | 5 | Address of the PHY found |
| scan_id | output | 32 | Identifier of the PHY found |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
A host write finishes exactly 131 half-periods plus one registered cycle after the accepting edge, and a read finishes after 129 half-periods plus one cycle. The bench counts clock edges from the accepting edge to the done pulse and compares the count with those figures, sampling one time unit after each edge. The PHY model in the bench reacts to management clock rising edges and drives each response bit at the start of a high phase. The design samples it HALF_DIV cycles later, so the reply is always due in the same phase. Scan results have no fixed latency, so the bench waits for scan_done and then compares the address and identifier it computed from the model's contents.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PRE_BITS    = 32;
  localparam int WR_CMD_BITS = 32;
  localparam int RD_CMD_BITS = 14;
  localparam int DATA_BITS   = 16;
  localparam int ADDR_BITS   = 5;
  localparam int FRAME_BITS  = PRE_BITS + WR_CMD_BITS;
  localparam int CNT_W       = $clog2(FRAME_BITS);

  localparam logic [ADDR_BITS-1:0] REG_STATUS = 5'd1;
  localparam logic [ADDR_BITS-1:0] REG_ID_HI  = 5'd2;
  localparam logic [ADDR_BITS-1:0] REG_ID_LO  = 5'd3;
  localparam logic [ADDR_BITS-1:0] SCAN_FIRST = 5'd1;

  typedef enum logic [3:0] {
    E_IDLE, E_DLOW, E_DHIGH, E_FIN, E_TLOW, E_THIGH,
    E_RLOW, E_RHIGH, E_ELOW, E_EHIGH
  } eng_state_e;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} scan_state_e;

  typedef enum logic [1:0] {
    STEP_STAT_A, STEP_STAT_B, STEP_ID_HI, STEP_ID_LO
  } scan_step_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic                 wr,
    input logic [ADDR_BITS-1:0] phy,
    input logic [ADDR_BITS-1:0] ra,
    input logic [DATA_BITS-1:0] d
  );
    if (wr)
      build_frame = {{PRE_BITS{1'b1}}, 2'b01, 2'b01, phy, ra, 2'b10, d};
    else
      build_frame = {{PRE_BITS{1'b1}}, 2'b01, 2'b10, phy, ra, 18'h0};
  endfunction

endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
  parameter int HALF_DIV = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);
  generate
    if (HALF_DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt;
      assign tick = run && (cnt == CW'(HALF_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || clear || !run) cnt <= '0;
        else if (tick)            cnt <= '0;
        else                      cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 wr,
  input  logic [ADDR_BITS-1:0] phy,
  input  logic [ADDR_BITS-1:0] regad,
  input  logic [DATA_BITS-1:0] wdata,
  input  logic                 tick,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 done,
  output logic                 ack,
  output logic [DATA_BITS-1:0] rdata,
  output logic                 mdc,
  output logic                 mdio_o,
  output logic                 mdio_oe
);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(PRE_BITS + WR_CMD_BITS - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(PRE_BITS + RD_CMD_BITS - 1);
  localparam logic [CNT_W-1:0] DT_LAST = CNT_W'(DATA_BITS - 1);

  eng_state_e               st;
  logic [FRAME_BITS-1:0]    sr;
  logic [CNT_W-1:0]         cnt;
  logic                     is_rd;
  logic                     ack_bit;
  logic [DATA_BITS-1:0]     shin;
  logic [FRAME_BITS-1:0]    frame_new;

  assign frame_new = build_frame(wr, phy, regad, wdata);
  assign busy      = (st != E_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= E_IDLE;
      sr      <= '0;
      cnt     <= '0;
      is_rd   <= 1'b0;
      ack_bit <= 1'b0;
      shin    <= '0;
      done    <= 1'b0;
      ack     <= 1'b0;
      rdata   <= '0;
      mdc     <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == E_IDLE) begin
        if (start) begin
          sr      <= frame_new;
          cnt     <= wr ? WR_LAST : RD_LAST;
          is_rd   <= ~wr;
          mdio_o  <= frame_new[FRAME_BITS-1];
          mdio_oe <= 1'b1;
          mdc     <= 1'b0;
          st      <= E_DLOW;
        end
      end else if (tick) begin
        case (st)
          E_DLOW: begin
            mdc <= 1'b1;
            st  <= E_DHIGH;
          end
          E_DHIGH: begin
            mdc <= 1'b0;
            if (cnt == '0) begin
              st <= E_FIN;
            end else begin
              sr     <= {sr[FRAME_BITS-2:0], 1'b0};
              mdio_o <= sr[FRAME_BITS-2];
              cnt    <= cnt - 1'b1;
              st     <= E_DLOW;
            end
          end
          E_FIN: begin
            mdio_oe <= 1'b0;
            st      <= E_TLOW;
          end
          E_TLOW: begin
            mdc <= 1'b1;
            st  <= E_THIGH;
          end
          E_THIGH: begin
            mdc <= 1'b0;
            if (is_rd) begin
              ack_bit <= ~mdio_i;
              cnt     <= DT_LAST;
              st      <= E_RLOW;
            end else begin
              ack  <= 1'b1;
              done <= 1'b1;
              st   <= E_IDLE;
            end
          end
          E_RLOW: begin
            mdc <= 1'b1;
            st  <= E_RHIGH;
          end
          E_RHIGH: begin
            mdc  <= 1'b0;
            shin <= {shin[DATA_BITS-2:0], mdio_i};
            if (cnt == '0) begin
              st <= E_ELOW;
            end else begin
              cnt <= cnt - 1'b1;
              st  <= E_RLOW;
            end
          end
          E_ELOW: begin
            mdc <= 1'b1;
            st  <= E_EHIGH;
          end
          E_EHIGH: begin
            mdc   <= 1'b0;
            ack   <= ack_bit;
            rdata <= ack_bit ? shin : {DATA_BITS{1'b1}};
            done  <= 1'b1;
            st    <= E_IDLE;
          end
          default: st <= E_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_scan.sv
module mdio_scan
  import mdio_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   go,
  input  logic                   eng_done,
  input  logic [DATA_BITS-1:0]   eng_rdata,
  output logic                   active,
  output logic                   req,
  output logic [ADDR_BITS-1:0]   req_phy,
  output logic [ADDR_BITS-1:0]   req_reg,
  output logic                   done,
  output logic                   found,
  output logic [ADDR_BITS-1:0]   addr,
  output logic [2*DATA_BITS-1:0] id
);
  scan_state_e          st;
  scan_step_e           step;
  logic [ADDR_BITS-1:0] cur;
  logic [DATA_BITS-1:0] id_hi;
  logic                 live;

  assign active  = (st != S_IDLE);
  assign req_phy = cur;
  assign live    = (eng_rdata != '0) && (eng_rdata != {DATA_BITS{1'b1}});

  always_comb begin
    case (step)
      STEP_ID_HI: req_reg = REG_ID_HI;
      STEP_ID_LO: req_reg = REG_ID_LO;
      default:    req_reg = REG_STATUS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      step  <= STEP_STAT_A;
      cur   <= SCAN_FIRST;
      id_hi <= '0;
      req   <= 1'b0;
      done  <= 1'b0;
      found <= 1'b0;
      addr  <= '0;
      id    <= '0;
    end else begin
      done <= 1'b0;
      req  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (go) begin
            cur  <= SCAN_FIRST;
            step <= STEP_STAT_A;
            st   <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          req <= 1'b1;
          st  <= S_WAIT;
        end
        S_WAIT: begin
          if (eng_done) begin
            case (step)
              STEP_STAT_A: begin
                step <= STEP_STAT_B;
                st   <= S_ISSUE;
              end
              STEP_STAT_B: begin
                if (live) begin
                  step <= STEP_ID_HI;
                  st   <= S_ISSUE;
                end else if (cur == '0) begin
                  found <= 1'b0;
                  addr  <= '0;
                  id    <= '0;
                  done  <= 1'b1;
                  st    <= S_IDLE;
                end else begin
                  cur  <= cur + 1'b1;
                  step <= STEP_STAT_A;
                  st   <= S_ISSUE;
                end
              end
              STEP_ID_HI: begin
                id_hi <= eng_rdata;
                step  <= STEP_ID_LO;
                st    <= S_ISSUE;
              end
              default: begin
                found <= 1'b1;
                addr  <= cur;
                id    <= {id_hi, eng_rdata};
                done  <= 1'b1;
                st    <= S_IDLE;
              end
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 40
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        op_start,
  input  logic        op_write,
  input  logic [4:0]  op_phy,
  input  logic [4:0]  op_reg,
  input  logic [15:0] op_wdata,
  input  logic        scan_start,
  output logic        busy,
  output logic        op_done,
  output logic        op_ack,
  output logic [15:0] op_rdata,
  output logic        scan_done,
  output logic        scan_found,
  output logic [4:0]  scan_addr,
  output logic [31:0] scan_id,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                 eng_busy, eng_done, eng_ack, tick;
  logic [DATA_BITS-1:0] eng_rdata;
  logic                 scan_active, scan_req;
  logic [ADDR_BITS-1:0] scan_phy, scan_reg;
  logic                 host_go, scan_go, eng_start;
  logic                 e_wr;
  logic [ADDR_BITS-1:0] e_phy, e_reg;

  assign busy      = eng_busy | scan_active;
  assign scan_go   = scan_start & ~busy;
  assign host_go   = op_start & ~busy & ~scan_start;
  assign eng_start = host_go | scan_req;
  assign e_wr      = scan_active ? 1'b0     : op_write;
  assign e_phy     = scan_active ? scan_phy : op_phy;
  assign e_reg     = scan_active ? scan_reg : op_reg;

  mdio_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst(rst), .clear(eng_start), .run(eng_busy), .tick(tick)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .wr(e_wr), .phy(e_phy),
    .regad(e_reg), .wdata(op_wdata), .tick(tick), .mdio_i(mdio_i),
    .busy(eng_busy), .done(eng_done), .ack(eng_ack), .rdata(eng_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_scan u_scan (
    .clk(clk), .rst(rst), .go(scan_go), .eng_done(eng_done),
    .eng_rdata(eng_rdata), .active(scan_active), .req(scan_req),
    .req_phy(scan_phy), .req_reg(scan_reg), .done(scan_done),
    .found(scan_found), .addr(scan_addr), .id(scan_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_done  <= 1'b0;
      op_ack   <= 1'b0;
      op_rdata <= '0;
    end else begin
      op_done <= eng_done & ~scan_active;
      if (eng_done && !scan_active) begin
        op_ack   <= eng_ack;
        op_rdata <= eng_rdata;
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HALF_DIV = 40
) (
  input logic        clk,
  input logic        rst,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        op_done,
  input logic        op_ack,
  input logic [15:0] op_rdata,
  input logic        scan_done,
  input logic        scan_found,
  input logic [31:0] scan_id
);
  int hi_cnt;
  always_ff @(posedge clk) begin
    if (rst)      hi_cnt <= 0;
    else if (mdc) hi_cnt <= hi_cnt + 1;
    else          hi_cnt <= 0;
  end

  assert_hi_phase_R1: assert property (@(posedge clk) disable iff (rst)
    (!mdc && $past(mdc)) |-> (hi_cnt == HALF_DIV));

  assert_bit_stable_R1: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_release_low_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(mdio_oe) |-> !mdc);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    op_done |=> !op_done);

  assert_noack_ones_R5: assert property (@(posedge clk) disable iff (rst)
    (op_done && !op_ack) |-> (op_rdata == 16'hFFFF));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  assert_notfound_id_R11: assert property (@(posedge clk) disable iff (rst)
    (scan_done && !scan_found) |-> (scan_id == 32'h0));
endmodule

bind mdio_master mdio_master_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .op_done(op_done), .op_ack(op_ack), .op_rdata(op_rdata),
  .scan_done(scan_done), .scan_found(scan_found), .scan_id(scan_id)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam int H = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_start = 1'b0, op_write = 1'b0, scan_start = 1'b0;
  logic [4:0] op_phy = '0, op_reg = '0;
  logic [15:0] op_wdata = '0;
  logic busy, op_done, op_ack, scan_done, scan_found, mdc, mdio_o, mdio_oe;
  logic [15:0] op_rdata;
  logic [4:0] scan_addr;
  logic [31:0] scan_id;
  logic mdio_i = 1'b1;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  mdio_master #(.HALF_DIV(H)) i_mdio_master (
    .clk(clk), .rst(rst), .op_start(op_start), .op_write(op_write),
    .op_phy(op_phy), .op_reg(op_reg), .op_wdata(op_wdata),
    .scan_start(scan_start), .busy(busy), .op_done(op_done), .op_ack(op_ack),
    .op_rdata(op_rdata), .scan_done(scan_done), .scan_found(scan_found),
    .scan_addr(scan_addr), .scan_id(scan_id), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // ---------------- PHY model ----------------
  logic [15:0] mreg [32];
  logic [4:0]  m_addr = 5'd1;
  bit          m_present = 1'b0;
  logic [15:0] stat_a = 16'h7809, stat_b = 16'h7809;
  int          stat_reads = 0;
  int          ones = 0, nb = 0, rcnt = 0;
  bit          in_frame = 0, pend_read = 0, resp = 0;
  logic [31:0] fr = '0;
  logic [15:0] rword = '0;
  int          last_pre = 0, last_cmd = 0;
  logic [31:0] last_wframe = '0;

  always @(posedge mdc) begin
    if (mdio_oe) begin
      if (!in_frame) begin
        if (mdio_o) ones++;
        else begin
          if (ones >= 32) begin
            in_frame = 1; fr = 32'h0; nb = 1; last_pre = ones;
          end
          ones = 0;
        end
      end else begin
        fr = {fr[30:0], mdio_o};
        nb++;
        if (nb == 14 && fr[13:10] == 4'b0110) begin
          in_frame = 0; last_cmd = 14; pend_read = 1; rcnt = 0;
          resp = m_present && (fr[9:5] == m_addr);
          if (resp) begin
            if (fr[4:0] == 5'd1) begin
              rword = (stat_reads % 2 == 0) ? stat_a : stat_b;
              stat_reads++;
            end else rword = mreg[fr[4:0]];
          end
        end else if (nb == 32) begin
          in_frame = 0; last_cmd = 32; last_wframe = fr;
          if (m_present && fr[27:23] == m_addr) mreg[fr[22:18]] = fr[15:0];
        end
      end
    end else if (pend_read) begin
      if (rcnt == 0)       mdio_i <= resp ? 1'b0 : 1'b1;
      else if (rcnt <= 16) mdio_i <= resp ? rword[16-rcnt] : 1'b1;
      else begin mdio_i <= 1'b1; pend_read = 0; end
      rcnt++;
    end
  end

  // ---------------- clock-shape monitor ----------------
  int run = 0, hi_min = 1000, hi_max = 0, rises = 0;
  logic mdc_prev = 1'b0;
  always @(posedge clk) begin
    if (mdc && !mdc_prev) rises++;
    mdc_prev = mdc;
    if (mdc) run++;
    else if (run > 0) begin
      if (run < hi_min) hi_min = run;
      if (run > hi_max) hi_max = run;
      run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic launch_op(input bit w, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d);
    @(negedge clk);
    op_start = 1; op_write = w; op_phy = p; op_reg = r; op_wdata = d;
    @(posedge clk);
    @(negedge clk);
    op_start = 0;
  endtask

  task automatic wait_op(output int n);
    n = 1;
    #1;
    while (!op_done && n < 5000) begin @(posedge clk); #1; n++; end
    if (!op_done) chk(0, "watchdog op", 0, 1);
  endtask

  task automatic wait_scan();
    int n = 0;
    while (!scan_done && n < 60000) begin @(posedge clk); #1; n++; end
    if (!scan_done) chk(0, "watchdog scan", 0, 1);
  endtask

  // n counted from accepting edge: edges after acceptance up to the done edge
  task automatic do_op(input bit w, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d, output int n);
    @(negedge clk);
    op_start = 1; op_write = w; op_phy = p; op_reg = r; op_wdata = d;
    rises = 0;
    @(posedge clk);
    n = 0;
    #1;
    op_start = 0;
    while (!op_done && n < 5000) begin @(posedge clk); n++; #1; end
    if (!op_done) chk(0, "watchdog op", 0, 1);
  endtask

  task automatic t_reset();
    chk(mdc == 0 && mdio_oe == 0, "R10 idle lines", {mdc, mdio_oe}, 0);
    chk(busy == 0 && op_done == 0 && scan_done == 0, "R10 idle flags",
        {busy, op_done, scan_done}, 0);
  endtask

  task automatic t_write();
    int n;
    m_present = 1; m_addr = 5'd4;
    hi_min = 1000; hi_max = 0;
    do_op(1, 5'd4, 5'd9, 16'hA5C3, n);
    chk(n == 131*H+1, "R2 write latency", n, 131*H+1);
    chk(op_ack == 1, "R2 write ack", op_ack, 1);
    chk(last_pre == 32, "R1 preamble ones", last_pre, 32);
    chk(last_cmd == 32, "R2 write bits", last_cmd, 32);
    chk(last_wframe == {2'b01, 2'b01, 5'd4, 5'd9, 2'b10, 16'hA5C3},
        "R2 write frame", last_wframe, {2'b01, 2'b01, 5'd4, 5'd9, 2'b10, 16'hA5C3});
    chk(rises == 65, "R2 write clock rises", rises, 65);
    chk(hi_min == H && hi_max == H, "R1 high phase length", {hi_min[15:0], hi_max[15:0]},
        {16'(H), 16'(H)});
  endtask

  task automatic t_read();
    int n;
    do_op(0, 5'd4, 5'd9, 16'h0, n);
    chk(n == 129*H+1, "R4 read latency", n, 129*H+1);
    chk(op_ack == 1 && op_rdata == 16'hA5C3, "R4 read data", {op_ack, op_rdata},
        {1'b1, 16'hA5C3});
    chk(last_cmd == 14 && last_pre == 32, "R3 read bits", last_cmd, 14);
    chk(rises == 64, "R3 read clock rises", rises, 64);
    mreg[17] = 16'h0001;
    do_op(0, 5'd4, 5'd17, 16'h0, n);
    chk(op_rdata == 16'h0001 && op_ack, "R4 read low pattern", op_rdata, 16'h0001);
  endtask

  task automatic t_noack();
    int n;
    do_op(0, 5'd12, 5'd2, 16'h0, n);
    chk(op_ack == 0, "R5 no ack flag", op_ack, 0);
    chk(op_rdata == 16'hFFFF, "R5 forced ones", op_rdata, 16'hFFFF);
  endtask

  task automatic t_busy_ignore();
    int n, extra;
    launch_op(1, 5'd4, 5'd5, 16'h1111);
    repeat (20) @(posedge clk);
    @(negedge clk);
    op_start = 1; op_write = 1; op_reg = 5'd5; op_wdata = 16'h2222; scan_start = 1;
    @(negedge clk);
    op_start = 0; scan_start = 0;
    wait_op(n);
    extra = 0;
    repeat (400) begin @(posedge clk); #1; if (op_done || scan_done || busy) extra++; end
    chk(extra == 0, "R6 no extra activity", extra, 0);
    do_op(0, 5'd4, 5'd5, 16'h0, n);
    chk(op_rdata == 16'h1111, "R6 register unchanged", op_rdata, 16'h1111);
  endtask

  task automatic run_scan(input bit pres, input logic [4:0] a, input logic [15:0] sa,
                          input logic [15:0] sb, input bit exp_found,
                          input string tag);
    m_present = pres; m_addr = a; stat_a = sa; stat_b = sb; stat_reads = 0;
    mreg[2] = 16'h0181; mreg[3] = {11'h5B8, a};
    @(negedge clk); scan_start = 1;
    @(negedge clk); scan_start = 0;
    wait_scan();
    chk(scan_found == exp_found, {tag, " found"}, scan_found, exp_found);
    if (exp_found) begin
      chk(scan_addr == a, {tag, " addr"}, scan_addr, a);
      chk(scan_id == {16'h0181, 11'h5B8, a}, {tag, " R9 id"}, scan_id,
          {16'h0181, 11'h5B8, a});
    end else begin
      chk(scan_addr == 0 && scan_id == 0, {tag, " empty result"}, scan_id, 0);
    end
    repeat (5) @(posedge clk);
  endtask

  initial begin
    #4_000_000;
    chk(0, "watchdog global", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mreg[i] = 16'h0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    repeat (2) @(posedge clk); #1;
    t_reset();
    t_write();
    t_read();
    t_noack();
    t_busy_ignore();
    run_scan(1, 5'd1,  16'h7809, 16'h7809, 1, "R7 first address");
    run_scan(1, 5'd0,  16'h7809, 16'h782D, 1, "R7 wrap to zero");
    run_scan(1, 5'd31, 16'hFFFF, 16'h782D, 1, "R8 second read decides");
    run_scan(1, 5'd5,  16'h7809, 16'h0000, 0, "R8 zero status");
    run_scan(1, 5'd7,  16'h7809, 16'hFFFF, 0, "R8 ones status");
    run_scan(0, 5'd1,  16'h7809, 16'h7809, 0, "R11 nothing present");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule